// File: doc/BRIEF.md
# Indirect Configuration Byte Window with Pin Controller

This block puts a bank of 8-bit internal configuration registers behind one 16-bit host word. The word carries a 7-bit register index in bits [14:8], an 8-bit data value in bits [7:0] and a store flag in bit 15. A host write always loads the index into a pointer. When the store flag is set, the same write also stores the data byte into the indexed register. A host read returns the byte that the pointer currently selects.

Part of the bank drives a pin controller for `NUM_PINS` pins (up to 64). The bank holds one output-value bit per pin, one direction bit per pin, and one 3-bit function code per pin, two codes to a byte. A misc-config byte selects the external management-bus mux. Its effective polarity depends on a strap bit. Strap bytes come in as inputs and can only be read. One strap bit chooses which port carries the serial transceiver.

A two-state machine serves host accesses. In `ST_IDLE` no response is pending. A read that has no write in the same cycle takes the transition `GO_RESP` into `ST_RESP`. `ST_RESP` drives `host_rvalid` for one cycle. From `ST_RESP` the machine goes back to `ST_IDLE` (`BACK_IDLE`), or it stays in `ST_RESP` if another read arrives (`STAY_RESP`). An idle cycle keeps the machine in `ST_IDLE` (`HOLD_IDLE`).

Top module: `cfgwin_gpio`

## Requirements
- R1: A host write with bit 15 clear loads bits [14:8] into the pointer and changes no internal register.
- R2: A host write with bit 15 set stores bits [7:0] into the register indexed by bits [14:8], and it also loads that index into the pointer.
- R3: A host read with `host_wr` low raises `host_rvalid` in the next cycle. `host_rdata` then holds 0 in bit 15, the pointer in [14:8] and the selected byte in [7:0]. Reads on consecutive cycles each give a response.
- R4: Output-value bytes sit at indices 0x10 and up, and direction bytes at 0x18 and up. Pin n uses byte base+n/8, bit n mod 8. `gpio_out` follows the value bits, and `gpio_oe` is the inverse of the direction bits.
- R5: A direction bit of 1 makes the pin an input and 0 makes it an output. A read of a value byte returns the stored bit for an output pin. For an input pin it returns the pin level after a two-flop synchronizer.
- R6: Function bytes sit at 0x20 + n/2. An even pin uses bits [2:0] and an odd pin uses bits [6:4]. They drive `gpio_func[3n+2:3n]`. Bits 3 and 7 read back as 0.
- R7: Strap bytes at 0x70 and up return `strap_in` and ignore writes.
- R8: `serdes_port` is 5 when strap byte 1 bit 0 is 1 and 4 otherwise.
- R9: `ext_mgmt_sel` equals bit 0 of the misc byte (index 0x60) when strap byte 0 bit 0 (no-CPU) is 1, and its inverse when that bit is 0.
- R10: Unmapped indices read as 0x00 and ignore writes.
- R11: After reset all pins are inputs, the output values are 0, the function codes are 0 and the pointer is 0.
- R12: A read in the same cycle as a write is dropped (no response). The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Window write strobe |
| host_rd | input | 1 | Window read strobe |
| host_wdata | input | 16 | Store flag, index and data byte |
| host_rdata | output | 16 | Read response word |
| host_rvalid | output | 1 | Response valid, one cycle per read |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| strap_in | input | NUM_STRAP*8 | Strap configuration bytes |
| gpio_out | output | NUM_PINS | Pin output values |
| gpio_oe | output | NUM_PINS | Pin output enables |
| gpio_func | output | NUM_PINS*3 | Per-pin function codes |
| ext_mgmt_sel | output | 1 | Effective external management-bus mux select |
| serdes_port | output | 3 | Port that carries the serial transceiver |

## Verification
A write updates the pointer and the stored registers at the clock edge that samples it, so `gpio_out`, `gpio_oe`, `gpio_func` and `ext_mgmt_sel` are checked at the falling edge that follows. A read response arrives exactly one cycle after the read strobe. The driver pushes the expected word when it raises the strobe, and the monitor pops it at the next falling edge, where `host_rvalid` must be high. A pin change needs two edges to pass the synchronizer, so the bench waits three cycles before it reads an input pin back.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    localparam int IDX_W     = 7;
    localparam int IDX_DATA  = 'h10;
    localparam int IDX_DIR   = 'h18;
    localparam int IDX_FUNC  = 'h20;
    localparam int IDX_MISC  = 'h60;
    localparam int IDX_STRAP = 'h70;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } host_state_t;
endpackage

// File: rtl/cfgwin_sync.sv
module cfgwin_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign d_out = stage2_q;
endmodule

// File: rtl/cfgwin_host_fsm.sv
module cfgwin_host_fsm
    import cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [15:0]      wdata,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_byte,
    output logic [15:0]      rdata,
    output logic             rvalid
);
    host_state_t      state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [15:0]      resp_q;
    logic             rd_go;

    assign rd_go = rd_en & ~wr_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: HOLD_IDLE, GO_RESP, STAY_RESP, BACK_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // pointer and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            resp_q <= '0;
        end else begin
            if (wr_en) ptr_q <= wdata[14:8];
            if (rd_go) resp_q <= {1'b0, ptr_q, rd_byte};
        end
    end

    // outputs
    always_comb begin
        rvalid  = (state_q == ST_RESP);
        rdata   = rvalid ? resp_q : 16'h0000;
        wr_stb  = wr_en & wdata[15];
        wr_idx  = wdata[14:8];
        wr_byte = wdata[7:0];
        rd_idx  = ptr_q;
    end

    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rvalid); // R3
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> !rvalid); // R12
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx == $past(wdata[14:8]))); // R1
endmodule

// File: rtl/cfgwin_regbank.sv
module cfgwin_regbank
    import cfgwin_pkg::*;
#(
    parameter int NUM_PINS  = 16,
    parameter int NUM_STRAP = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_stb,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_byte,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_byte,
    input  logic [NUM_PINS-1:0]   pin_sync,
    input  logic [NUM_STRAP*8-1:0] strap_bytes,
    output logic [NUM_PINS-1:0]   gpio_out,
    output logic [NUM_PINS-1:0]   gpio_oe,
    output logic [NUM_PINS*3-1:0] gpio_func,
    output logic [7:0]            misc_byte
);
    localparam int BIT_BYTES  = (NUM_PINS + 7) / 8;
    localparam int FUNC_BYTES = (NUM_PINS + 1) / 2;
    localparam int BIT_W      = BIT_BYTES * 8;

    logic [BIT_W-1:0]      data_q;
    logic [BIT_W-1:0]      dir_q;
    logic [NUM_PINS*3-1:0] func_q;
    logic [7:0]            misc_q;
    logic [BIT_W-1:0]      pin_pad;
    logic [BIT_W-1:0]      data_view;
    logic [7:0]            func_rd [FUNC_BYTES];
    logic                  in_func;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '1;
            func_q <= '0;
            misc_q <= '0;
        end else if (wr_stb) begin
            for (int b = 0; b < BIT_BYTES; b++) begin
                if (wr_idx == IDX_W'(IDX_DATA + b)) data_q[b*8 +: 8] <= wr_byte;
                if (wr_idx == IDX_W'(IDX_DIR + b))  dir_q[b*8 +: 8]  <= wr_byte;
            end
            for (int p = 0; p < NUM_PINS; p++) begin
                if (wr_idx == IDX_W'(IDX_FUNC + p / 2))
                    func_q[p*3 +: 3] <= (p % 2 == 1) ? wr_byte[6:4] : wr_byte[2:0];
            end
            if (wr_idx == IDX_W'(IDX_MISC)) misc_q <= wr_byte;
        end
    end

    always_comb begin
        pin_pad = '0;
        pin_pad[NUM_PINS-1:0] = pin_sync;
    end

    assign data_view = (dir_q & pin_pad) | (~dir_q & data_q);

    genvar k;
    generate
        for (k = 0; k < FUNC_BYTES; k++) begin : g_func_rd
            if (2 * k + 1 < NUM_PINS) begin : g_pair
                assign func_rd[k] = {1'b0, func_q[(2*k+1)*3 +: 3], 1'b0, func_q[(2*k)*3 +: 3]};
            end else begin : g_single
                assign func_rd[k] = {5'b00000, func_q[(2*k)*3 +: 3]};
            end
        end
    endgenerate

    always_comb begin
        rd_byte = 8'h00;
        for (int b = 0; b < BIT_BYTES; b++) begin
            if (rd_idx == IDX_W'(IDX_DATA + b)) rd_byte = data_view[b*8 +: 8];
            if (rd_idx == IDX_W'(IDX_DIR + b))  rd_byte = dir_q[b*8 +: 8];
        end
        for (int f = 0; f < FUNC_BYTES; f++) begin
            if (rd_idx == IDX_W'(IDX_FUNC + f)) rd_byte = func_rd[f];
        end
        if (rd_idx == IDX_W'(IDX_MISC)) rd_byte = misc_q;
        for (int s = 0; s < NUM_STRAP; s++) begin
            if (rd_idx == IDX_W'(IDX_STRAP + s)) rd_byte = strap_bytes[s*8 +: 8];
        end
    end

    assign gpio_out  = data_q[NUM_PINS-1:0];
    assign gpio_oe   = ~dir_q[NUM_PINS-1:0];
    assign gpio_func = func_q;
    assign misc_byte = misc_q;
    assign in_func   = (rd_idx >= IDX_W'(IDX_FUNC)) && (rd_idx < IDX_W'(IDX_FUNC + FUNC_BYTES));

    AST_HOLD_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(data_q) && $stable(dir_q) && $stable(func_q) && $stable(misc_q))); // R1
    AST_FUNC_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        in_func |-> (rd_byte[3] == 1'b0 && rd_byte[7] == 1'b0)); // R6
endmodule

// File: rtl/cfgwin_gpio.sv
module cfgwin_gpio
    import cfgwin_pkg::*;
#(
    parameter int NUM_PINS  = 16,
    parameter int NUM_STRAP = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [15:0]            host_wdata,
    output logic [15:0]            host_rdata,
    output logic                   host_rvalid,
    input  logic [NUM_PINS-1:0]    pin_in,
    input  logic [NUM_STRAP*8-1:0] strap_in,
    output logic [NUM_PINS-1:0]    gpio_out,
    output logic [NUM_PINS-1:0]    gpio_oe,
    output logic [NUM_PINS*3-1:0]  gpio_func,
    output logic                   ext_mgmt_sel,
    output logic [2:0]             serdes_port
);
    localparam int NOCPU_BIT  = 0;
    localparam int SERDES_BIT = 8;

    logic [NUM_PINS-1:0] pin_sync;
    logic [IDX_W-1:0]    rd_idx;
    logic [IDX_W-1:0]    wr_idx;
    logic [7:0]          rd_byte;
    logic [7:0]          wr_byte;
    logic [7:0]          misc_byte;
    logic                wr_stb;

    cfgwin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (pin_sync)
    );

    cfgwin_host_fsm u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .rd_en   (host_rd),
        .wdata   (host_wdata),
        .rd_byte (rd_byte),
        .rd_idx  (rd_idx),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_byte (wr_byte),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    cfgwin_regbank #(.NUM_PINS(NUM_PINS), .NUM_STRAP(NUM_STRAP)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_idx      (wr_idx),
        .wr_byte     (wr_byte),
        .rd_idx      (rd_idx),
        .rd_byte     (rd_byte),
        .pin_sync    (pin_sync),
        .strap_bytes (strap_in),
        .gpio_out    (gpio_out),
        .gpio_oe     (gpio_oe),
        .gpio_func   (gpio_func),
        .misc_byte   (misc_byte)
    );

    assign ext_mgmt_sel = strap_in[NOCPU_BIT] ? misc_byte[0] : ~misc_byte[0];
    assign serdes_port  = strap_in[SERDES_BIT] ? 3'd5 : 3'd4;

    AST_SERDES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (serdes_port == 3'd4) || (serdes_port == 3'd5)); // R8
    AST_RESP_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (host_rdata[15] == 1'b0)); // R3
endmodule

// File: tb/cfgwin_gpio_test.sv
module cfgwin_gpio_test;
    localparam int NP = 16;
    localparam int NS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          host_rvalid;
    logic [NP-1:0] pin_in = '0;
    logic [NS*8-1:0] strap_in = 16'h0101;
    logic [NP-1:0] gpio_out;
    logic [NP-1:0] gpio_oe;
    logic [NP*3-1:0] gpio_func;
    logic          ext_mgmt_sel;
    logic [2:0]    serdes_port;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    cfgwin_gpio #(.NUM_PINS(NP), .NUM_STRAP(NS)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .pin_in(pin_in), .strap_in(strap_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .gpio_func(gpio_func), .ext_mgmt_sel(ext_mgmt_sel), .serdes_port(serdes_port)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b0;
    endtask

    task automatic win_write(input logic upd, input logic [6:0] idx, input logic [7:0] val);
        @(negedge clk);
        host_wr    = 1'b1;
        host_rd    = 1'b0;
        host_wdata = {upd, idx, val};
        idle();
    endtask

    // raise the read strobe and push the expected response
    task automatic rd_issue(input logic [6:0] ptr, input logic [7:0] val, input string tag);
        @(negedge clk);
        host_wr = 1'b0;
        host_rd = 1'b1;
        exp_q.push_back({1'b0, ptr, val});
        tag_q.push_back(tag);
    endtask

    task automatic win_read(input logic [6:0] idx, input logic [7:0] val, input string tag);
        win_write(1'b0, idx, 8'h00);
        rd_issue(idx, val, tag);
        idle();
    endtask

    // monitor: compares every response with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R12: actual response %0h expected none", host_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    n_fails++;
                    $display("FAIL %s: actual %0h expected %0h", t, host_rdata, e);
                end
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R11 reset state
                check("R11 oe", 64'(gpio_oe), 64'h0);
                check("R11 out", 64'(gpio_out), 64'h0);
                check("R11 func", 64'(gpio_func), 64'h0);
                check("R11 rvalid", 64'(host_rvalid), 64'h0);
                rd_issue(7'h00, 8'h00, "R11 ptr zero");
                idle();
                win_read(7'h18, 8'hFF, "R11 dir all input");
                // R2 R4 direction and value stores
                win_write(1'b1, 7'h18, 8'h0F);
                check("R4 oe low byte", 64'(gpio_oe), 64'h00F0);
                win_write(1'b1, 7'h10, 8'hA5);
                check("R4 out low byte", 64'(gpio_out), 64'h00A5);
                // R5 mixed view
                win_read(7'h10, 8'hA0, "R5 view pins low");
                pin_in = 16'h0006;
                repeat (3) @(negedge clk);
                win_read(7'h10, 8'hA6, "R5 view pins synced");
                // R1 pointer-only write does not store
                win_write(1'b0, 7'h10, 8'hFF);
                check("R1 out unchanged", 64'(gpio_out), 64'h00A5);
                rd_issue(7'h10, 8'hA6, "R1 byte unchanged");
                idle();
                // R6 function fields
                win_write(1'b1, 7'h21, 8'hFF);
                check("R6 func pins2-3", 64'(gpio_func), 64'h0FC0);
                win_read(7'h21, 8'h77, "R6 readback gaps");
                win_write(1'b1, 7'h27, 8'h35);
                check("R6 func pin14-15", 64'(gpio_func[47:42]), 64'o35);
                // R4 upper byte
                win_write(1'b1, 7'h19, 8'h00);
                win_write(1'b1, 7'h11, 8'h3C);
                check("R4 oe high", 64'(gpio_oe), 64'hFFF0);
                check("R4 out high", 64'(gpio_out), 64'h3CA5);
                // R7 strap read-only
                strap_in = 16'h0101;
                win_read(7'h70, 8'h01, "R7 strap0");
                win_write(1'b1, 7'h70, 8'h55);
                rd_issue(7'h70, 8'h01, "R7 write ignored");
                idle();
                // R8 serdes selection
                check("R8 port5", 64'(serdes_port), 64'd5);
                strap_in = 16'h0001;
                #1;
                check("R8 port4", 64'(serdes_port), 64'd4);
                // R9 mux polarity
                win_write(1'b1, 7'h60, 8'h01);
                check("R9 nocpu1", 64'(ext_mgmt_sel), 64'd1);
                strap_in = 16'h0000;
                #1;
                check("R9 nocpu0", 64'(ext_mgmt_sel), 64'd0);
                // R10 unmapped
                win_write(1'b1, 7'h45, 8'hEE);
                rd_issue(7'h45, 8'h00, "R10 unmapped");
                idle();
                // R12 simultaneous write and read
                @(negedge clk);
                host_wr = 1'b1;
                host_rd = 1'b1;
                host_wdata = {1'b1, 7'h11, 8'h81};
                idle();
                check("R12 no response", 64'(host_rvalid), 64'd0);
                check("R12 write applied", 64'(gpio_out[15:8]), 64'h81);
                // R3 back-to-back reads
                rd_issue(7'h11, 8'h81, "R3 first");
                rd_issue(7'h11, 8'h81, "R3 second");
                idle();
                repeat (3) @(negedge clk);
                check("R3 queue drained", 64'(exp_q.size()), 64'd0);
            end
            begin
                repeat (20000) @(negedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule